// File: doc/BRIEF.md
# Nibble-Tagged Sample Serial Packer

This block accepts 16-bit conversion results from a fast source, one per clock when its valid strobe is high, and sends each one over a slow asynchronous serial line. Every sample is cut into four 4-bit slices. Each slice travels in its own 10-bit frame: a low start bit, eight data bits sent least significant first, and a high stop bit. The upper half of each frame byte holds a slice index, so a receiver can rebuild the word even if it loses its place in the stream.

A small first-in first-out store sits between the source and the serial engine, so a short burst of samples can arrive faster than the line can carry them. When the store is full, further samples are discarded and a sticky overflow flag rises. The flag stays high until the control side pulses a clear input. The length of one bit is set by a parameter, counted in system clocks.

Top module: `nibble_uart_packer`

## Requirements
- R1: When idle the line is high. Each frame is a start bit (0), then eight data bits with bit 0 first, then a stop bit (1). Every bit lasts exactly CLKS_PER_BIT clocks.
- R2: Each accepted sample produces exactly four frames. The first frame carries bits 15:12, then 11:8, then 7:4, and the last carries bits 3:0.
- R3: In each frame byte, bits 3:0 hold the slice, bits 5:4 hold the slice index (3 for bits 15:12, down to 0 for bits 3:0), and bits 7:6 are 0.
- R4: The four frames of one sample are contiguous. Each start bit begins in the clock right after the previous frame's stop bit ends.
- R5: Up to FIFO_DEPTH (default 4) samples are held, and they are sent in arrival order.
- R6: A sample that arrives while FIFO_DEPTH samples are held is discarded, and `overflow` is 1 from the next cycle on. The flag stays set until it is cleared.
- R7: A clear pulse makes `overflow` 0 in the next cycle. If a discard happens in the same cycle, the flag is set instead.
- R8: After reset the line is high, `overflow` is 0 and the store is empty.
- R9: A sample accepted while the block is completely idle drives its start bit from the second clock edge after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Sample strobe |
| sample_data | input | 16 | Conversion result |
| overflow_clear | input | 1 | Clears the overflow flag |
| overflow | output | 1 | Sticky discard flag |
| serial_out | output | 1 | Asynchronous serial line |

## Verification
An accepted sample takes two edges to reach the line: one to leave the store and one to load the shifter. Its start bit is therefore checked at the second edge after acceptance. Bit values are read at the middle of each bit period, CLKS_PER_BIT/2 clocks into the bit. Contiguity is checked by requiring a low level in the very clock after each of the first three stop bits. The overflow flag is compared against the reference on every falling edge, one cycle after the edge that set or cleared it. The reference's store releases a slot at the edge after the fourth frame of the sample in flight starts.

// File: rtl/nup_pkg.sv
package nup_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int SLICE_W    = 4;
  localparam int SLICES     = SAMPLE_W / SLICE_W;
  localparam int IDX_W      = 2;
  localparam int FRAME_BITS = 10;

  typedef logic [7:0] frame_byte_t;

  function automatic frame_byte_t make_frame(input logic [IDX_W-1:0] idx,
                                             input logic [SLICE_W-1:0] slice);
    return {2'b00, idx, slice};
  endfunction
endpackage

// File: rtl/nup_sample_fifo.sv
module nup_sample_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign rd_data = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_en ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = rd_en ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_en && !rd_en)      cnt_d = cnt_q + 1'b1;
    else if (!wr_en && rd_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R5
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty); // R5
endmodule

// File: rtl/nup_frame_seq.sv
module nup_frame_seq
  import nup_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fifo_empty,
  input  logic [SAMPLE_W-1:0] fifo_data,
  output logic                fifo_pop,
  output logic                byte_valid,
  output frame_byte_t         byte_data,
  input  logic                byte_ready
);
  logic                active_q, active_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [SAMPLE_W-1:0] smp_q, smp_d;

  assign fifo_pop   = !active_q && !fifo_empty;
  assign byte_valid = active_q;
  assign byte_data  = make_frame(idx_q, smp_q[idx_q*SLICE_W +: SLICE_W]);

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    smp_d    = smp_q;
    if (fifo_pop) begin
      active_d = 1'b1;
      idx_d    = IDX_W'(SLICES - 1);
      smp_d    = fifo_data;
    end else if (active_q && byte_ready) begin
      if (idx_q == '0) active_d = 1'b0;
      else             idx_d    = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      smp_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      smp_q    <= smp_d;
    end
  end

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data)); // R4
  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && byte_ready && (byte_data[5:4] != 2'd0)
    |=> byte_valid && (byte_data[5:4] == $past(byte_data[5:4]) - 2'd1)); // R2
endmodule

// File: rtl/nup_uart_tx.sv
module nup_uart_tx
  import nup_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  frame_byte_t byte_data,
  output logic        byte_ready,
  output logic        txd
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BW = $clog2(FRAME_BITS);

  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic [CW-1:0]         tick_q, tick_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic                  last_tick, last_bit, load;

  assign last_tick  = (tick_q == CW'(CLKS_PER_BIT - 1));
  assign last_bit   = (bit_q == BW'(FRAME_BITS - 1));
  assign byte_ready = !busy_q || (last_tick && last_bit);
  assign load       = byte_valid && byte_ready;
  assign txd        = busy_q ? shift_q[0] : 1'b1;

  always_comb begin
    busy_d  = busy_q;
    shift_d = shift_q;
    tick_d  = tick_q;
    bit_d   = bit_q;
    if (busy_q) begin
      if (last_tick) begin
        tick_d = '0;
        if (last_bit) begin
          busy_d = 1'b0;
        end else begin
          bit_d   = bit_q + 1'b1;
          shift_d = {1'b1, shift_q[FRAME_BITS-1:1]};
        end
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
    if (load) begin
      busy_d  = 1'b1;
      shift_d = {1'b1, byte_data, 1'b0};
      tick_d  = '0;
      bit_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      shift_q <= '1;
      tick_q  <= '0;
      bit_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      shift_q <= shift_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
    end
  end

  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> !txd); // R1
  AST_STOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && last_bit |-> txd); // R1
endmodule

// File: rtl/nibble_uart_packer.sv
module nibble_uart_packer
  import nup_pkg::*;
#(
  parameter int FIFO_DEPTH   = 4,
  parameter int CLKS_PER_BIT = 434
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_valid,
  input  logic [15:0] sample_data,
  input  logic        overflow_clear,
  output logic        overflow,
  output logic        serial_out
);
  logic                fifo_empty, fifo_full, fifo_pop, fifo_push;
  logic [SAMPLE_W-1:0] fifo_data;
  logic                byte_valid, byte_ready;
  frame_byte_t         byte_data;
  logic                ovf_q, ovf_d;

  assign fifo_push = sample_valid && !fifo_full;
  assign overflow  = ovf_q;

  always_comb begin
    ovf_d = ovf_q;
    if (sample_valid && fifo_full) ovf_d = 1'b1;
    else if (overflow_clear)       ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  nup_sample_fifo #(.WIDTH(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fifo_push), .wr_data(sample_data),
    .rd_en(fifo_pop), .rd_data(fifo_data),
    .empty(fifo_empty), .full(fifo_full)
  );

  nup_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready)
  );

  nup_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .txd(serial_out)
  );

  AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && fifo_full |=> overflow); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !overflow_clear |=> overflow); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_clear && !(sample_valid && fifo_full) |=> !overflow); // R7
endmodule

// File: tb/nibble_uart_packer_bench.sv
`timescale 1ns/1ps
module nibble_uart_packer_bench;
  localparam int C     = 8;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [15:0] sample_data = '0;
  logic        overflow_clear = 1'b0;
  logic        overflow, serial_out;

  always #2 clk = ~clk;

  nibble_uart_packer #(.FIFO_DEPTH(DEPTH), .CLKS_PER_BIT(C)) u_nibble_uart_packer (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_data(sample_data),
    .overflow_clear(overflow_clear), .overflow(overflow), .serial_out(serial_out)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model
  int         m_cnt = 0;
  bit         m_seq = 0;
  bit         m_free = 0;
  bit         m_ovf = 0;
  int         lat_target = -1;
  logic [7:0] exp_q[$];

  // receiver state
  bit         rx_active = 0;
  int         rx_t = 0;
  int         rx_fcount = 0;
  bit         expect_start = 0;
  logic [7:0] rx_byte;

  always @(posedge clk) begin
    if (rst_n) begin
      bit full_before, pop, idle;
      cyc++;
      full_before = (m_cnt >= DEPTH);
      idle = !m_seq && (m_cnt == 0) && !rx_active && !expect_start && (exp_q.size() == 0);
      pop = (!m_seq || m_free) && (m_cnt > 0);
      if (pop) begin m_cnt--; m_seq = 1; end
      else if (m_free) m_seq = 0;
      m_free = 0;
      if (sample_valid) begin
        if (!full_before) begin
          m_cnt++;
          for (int k = 3; k >= 0; k--)
            exp_q.push_back({2'b00, 2'(k), sample_data[k*4 +: 4]});
          if (idle) lat_target = cyc + 2;
        end else begin
          m_ovf = 1;
        end
      end
      if (!(sample_valid && full_before) && overflow_clear) m_ovf = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(overflow == m_ovf, "R6/R7 overflow", overflow, m_ovf);
      if (!rx_active) begin
        if (expect_start) begin
          check(serial_out == 1'b0, "R4 contiguous start", serial_out, 0);
          expect_start = 0;
        end
        if (serial_out == 1'b0) begin
          rx_active = 1;
          rx_t = 0;
          if (rx_fcount % 4 == 3) m_free = 1;
          if (lat_target >= 0) begin
            check(cyc == lat_target, "R9 start latency", cyc, lat_target);
            lat_target = -1;
          end
        end
      end
      if (rx_active) begin
        if (rx_t % C == C / 2) begin
          int b;
          b = rx_t / C;
          if (b == 0) check(serial_out == 1'b0, "R1 start bit", serial_out, 0);
          else if (b <= 8) rx_byte[b-1] = serial_out;
          else begin
            logic [7:0] e;
            check(serial_out == 1'b1, "R1 stop bit", serial_out, 1);
            check(rx_byte[7:6] == 2'b00, "R3 top bits zero", rx_byte[7:6], 0);
            check(rx_byte[5:4] == 2'(3 - rx_fcount % 4), "R2 slice order", rx_byte[5:4], 3 - rx_fcount % 4);
            if (exp_q.size() == 0) check(0, "R5 unexpected frame", rx_byte, 0);
            else begin
              e = exp_q.pop_front();
              check(rx_byte == e, "R3/R5 frame byte", rx_byte, e);
            end
          end
        end
        if (rx_t == 10 * C - 1) begin
          rx_active = 0;
          rx_fcount++;
          if (rx_fcount % 4 != 0) expect_start = 1;
        end else rx_t++;
      end
    end
  end

  task automatic push(input logic [15:0] d, input bit clr);
    @(posedge clk); #1;
    sample_valid = 1'b1; sample_data = d; overflow_clear = clr;
  endtask

  task automatic idle_inputs();
    @(posedge clk); #1;
    sample_valid = 1'b0; overflow_clear = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0 || rx_active || expect_start);
    repeat (2 * C) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(serial_out == 1'b1, "R8 line idle in reset", serial_out, 1);
    check(overflow == 1'b0, "R8 flag low in reset", overflow, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(serial_out == 1'b1, "R8 line idle after reset", serial_out, 1);

    // R1 R2 R3 R9: single sample into idle block
    push(16'hA5C3, 0); idle_inputs(); drain();
    // R4 R5: two samples back to back
    push(16'h1234, 0); push(16'h5678, 0); idle_inputs(); drain();
    // R3: extreme values
    push(16'h0000, 0); push(16'hFFFF, 0); idle_inputs(); drain();
    // R6: burst of six, one discarded
    for (int i = 0; i < 6; i++) push(16'h9000 + 16'(i * 16'h0111), 0);
    idle_inputs(); drain();
    check(overflow == 1'b1, "R6 flag held", overflow, 1);
    // R7: clear
    @(posedge clk); #1; overflow_clear = 1'b1;
    @(posedge clk); #1; overflow_clear = 1'b0;
    @(negedge clk);
    check(overflow == 1'b0, "R7 cleared", overflow, 0);
    // R7: clear coinciding with a discard, set wins
    for (int i = 0; i < 6; i++) push(16'h3C00 + 16'(i), i == 5);
    idle_inputs();
    @(negedge clk);
    check(overflow == 1'b1, "R7 set beats clear", overflow, 1);
    drain();
    finish_run();
  end
endmodule